// File: doc/BRIEF.md
# Pending Interrupt and Fault Capture Unit

This unit gathers the asynchronous-looking interrupt and error requests of a 16-level priority interrupt system into two registers. The inputs are active-low and are sampled in the system clock domain only when the machine-cycle sync strobe `sync_n` falls. Each interrupt pin sets one fixed pending level. Each error pin sets one fault bit, and any newly set fault also sets pending level 1. The fault bit used by a memory-protect error depends on whether the current bus cycle is a memory cycle or a DMA cycle. A protect error in a memory cycle also raises an abort request for the running instruction.

A mask register and a global enable gate the levels that reach the priority output. Level 0 (power down) bypasses both. The unit presents the lowest-numbered eligible level, with a valid flag, one clock after the state that produced it. Software clears pending and fault bits with write-one-to-clear strobes. Logic inside the processor sets the levels reserved for internal machine interrupts through a separate set vector.

Top module: `intr_fault_capture`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `pending`, `fault`, `mask_q`, `int_en`, `irq_valid`, `irq_level` and `abort_req` are all zero.
- R2: External inputs take effect only on a sync falling edge. Such an edge is a clock edge at which `sync_n` is low and was high at the previous clock edge. A low external input at any other clock edge changes neither `pending` nor `fault`.
- R3: A low `pwr_dn_n` at a sync falling edge sets `pending[0]`. While `pending[0]` is set, the next cycle shows `irq_valid`=1 and `irq_level`=0, whatever the mask and enable hold.
- R4: At a sync falling edge, a low `usr_irq_n[0..5]` sets pending levels 2, 8, 10, 11, 13 and 15 in that order. A low `io_irq_n[0]` sets level 12 and a low `io_irq_n[1]` sets level 14.
- R5: At a sync falling edge, `prot_err_n` low sets fault bit 0 when `cyc_is_dma`=0 and fault bit 1 when `cyc_is_dma`=1. Memory parity sets bit 2, programmed-I/O parity sets bit 3, DMA parity sets bit 4 and address error sets bit 8. Whenever any fault bit is set, `pending[1]` is set at the same clock edge.
- R6: A protect error captured with `cyc_is_dma`=0 raises `abort_req` for exactly the one cycle that follows the capturing edge. A protect error in a DMA cycle does not raise it.
- R7: A bit of `int_set` sets its pending level at any clock edge, but only at levels 1, 3, 4, 5, 6, 7 and 9 (mask 0x02FA). Set bits at any other position have no effect.
- R8: A one in `pend_clr` or `fault_clr` clears that bit at the next clock edge. When a set arrives at the same edge, the set wins.
- R9: When `cfg_we`=1, `mask_q` loads `mask_wdata` and `int_en` loads `en_wdata`. A mask bit of 1 lets its level through. One cycle after any state, `irq_level` shows the lowest-numbered level n≥1 with pending, mask and enable all set, and `irq_valid`=1. Level 0 overrides as in R3. `irq_valid`=0 when no level qualifies.
- R10: An input held low sets its bit again at every sync falling edge, even when the bit was cleared in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Machine-cycle sync strobe, falling edge samples inputs |
| pwr_dn_n | input | 1 | Power-down request, active low |
| usr_irq_n | input | 6 | User interrupt requests, active low |
| io_irq_n | input | 2 | I/O-dedicated interrupt requests, active low |
| prot_err_n | input | 1 | Memory protection error, active low |
| mem_par_err_n | input | 1 | Memory parity error, active low |
| pio_par_err_n | input | 1 | Programmed-I/O parity error, active low |
| dma_par_err_n | input | 1 | DMA parity error, active low |
| addr_err_n | input | 1 | External address error, active low |
| cyc_is_dma | input | 1 | Current bus cycle is a DMA cycle (0 = memory cycle) |
| int_set | input | 16 | Internal machine interrupt set vector |
| pend_clr | input | 16 | Write-one-to-clear strobe for pending bits |
| fault_clr | input | 16 | Write-one-to-clear strobe for fault bits |
| cfg_we | input | 1 | Load mask and enable |
| mask_wdata | input | 16 | New mask value |
| en_wdata | input | 1 | New global enable value |
| pending | output | 16 | Pending interrupt register |
| fault | output | 16 | Fault register |
| mask_q | output | 16 | Mask register |
| int_en | output | 1 | Global interrupt enable |
| irq_valid | output | 1 | A level is selected |
| irq_level | output | 4 | Selected level |
| abort_req | output | 1 | Abort request for a memory-cycle protect error |

## Verification
The hardest case to reach from the ports is a set and a clear of the same bit at the same clock edge. It needs a sync falling edge, a held-low input and a matching clear strobe to coincide. A second hard case is a bit cleared between two edges while its input stays low. Directed sequences build both cases explicitly. Random stimulus toggles the strobe, the clears, the configuration and the cycle type independently, so that edges also land on collisions and on protect errors of both cycle types.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  localparam int NLVL  = 16;
  localparam int LVL_W = $clog2(NLVL);
  localparam logic [NLVL-1:0] RESERVED_LVLS = 16'h02FA;

  localparam int L_POWER = 0;
  localparam int L_FAULT = 1;

  localparam int F_PROT_MEM = 0;
  localparam int F_PROT_DMA = 1;
  localparam int F_MEM_PAR  = 2;
  localparam int F_PIO_PAR  = 3;
  localparam int F_DMA_PAR  = 4;
  localparam int F_ADDR     = 8;

  function automatic int usr_lvl(input int idx);
    case (idx)
      0:       return 2;
      1:       return 8;
      2:       return 10;
      3:       return 11;
      4:       return 13;
      default: return 15;
    endcase
  endfunction

  function automatic int io_lvl(input int idx);
    return (idx == 0) ? 12 : 14;
  endfunction
endpackage

// File: rtl/ifc_sync_edge.sv
module ifc_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= strobe_n;
  end

  assign fall = prev_q & ~strobe_n;
endmodule

// File: rtl/ifc_capture.sv
module ifc_capture
  import ifc_pkg::*;
#(
  parameter int LEVELS  = NLVL,
  parameter int FAULT_W = 16,
  parameter int NUM_USR = 6,
  parameter int NUM_IO  = 2
) (
  input  logic               take,
  input  logic               pwr_n,
  input  logic [NUM_USR-1:0] usr_n,
  input  logic [NUM_IO-1:0]  io_n,
  input  logic               prot_n,
  input  logic               mpar_n,
  input  logic               pio_n,
  input  logic               dpar_n,
  input  logic               addr_n,
  input  logic               is_dma,
  input  logic [LEVELS-1:0]  internal_set,
  output logic [LEVELS-1:0]  pend_set,
  output logic [FAULT_W-1:0] fault_set,
  output logic               abort_set
);
  logic [LEVELS-1:0] ext_set;

  always_comb begin
    fault_set = '0;
    if (take) begin
      fault_set[F_PROT_MEM] = ~prot_n & ~is_dma;
      fault_set[F_PROT_DMA] = ~prot_n & is_dma;
      fault_set[F_MEM_PAR]  = ~mpar_n;
      fault_set[F_PIO_PAR]  = ~pio_n;
      fault_set[F_DMA_PAR]  = ~dpar_n;
      fault_set[F_ADDR]     = ~addr_n;
    end
  end

  always_comb begin
    ext_set = '0;
    if (take) begin
      ext_set[L_POWER] = ~pwr_n;
      for (int u = 0; u < NUM_USR; u++)
        if (!usr_n[u]) ext_set[usr_lvl(u)] = 1'b1;
      for (int k = 0; k < NUM_IO; k++)
        if (!io_n[k]) ext_set[io_lvl(k)] = 1'b1;
    end
    ext_set[L_FAULT] = ext_set[L_FAULT] | (|fault_set);
  end

  assign pend_set  = ext_set | (internal_set & RESERVED_LVLS[LEVELS-1:0]);
  assign abort_set = take & ~prot_n & ~is_dma;
endmodule

// File: rtl/ifc_w1c_reg.sv
module ifc_w1c_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_bits) | set_bits;
  end
endmodule

// File: rtl/ifc_prio.sv
module ifc_prio
  import ifc_pkg::*;
#(
  parameter int LEVELS = NLVL,
  localparam int LW    = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEVELS-1:0] pend,
  input  logic [LEVELS-1:0] mask,
  input  logic              enable,
  output logic              valid,
  output logic [LW-1:0]     level
);
  logic [LEVELS-1:0] cand;
  logic              hit;
  logic [LW-1:0]     pick;

  assign cand = pend & mask & {LEVELS{enable}};

  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int i = LEVELS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit  = 1'b1;
        pick = LW'(i);
      end
    end
    if (pend[L_POWER]) begin
      hit  = 1'b1;
      pick = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      level <= '0;
    end else begin
      valid <= hit;
      level <= pick;
    end
  end
endmodule

// File: rtl/intr_fault_capture.sv
module intr_fault_capture
  import ifc_pkg::*;
#(
  parameter int LEVELS  = NLVL,
  parameter int FAULT_W = 16,
  parameter int NUM_USR = 6,
  parameter int NUM_IO  = 2,
  localparam int LW     = $clog2(LEVELS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sync_n,
  input  logic               pwr_dn_n,
  input  logic [NUM_USR-1:0] usr_irq_n,
  input  logic [NUM_IO-1:0]  io_irq_n,
  input  logic               prot_err_n,
  input  logic               mem_par_err_n,
  input  logic               pio_par_err_n,
  input  logic               dma_par_err_n,
  input  logic               addr_err_n,
  input  logic               cyc_is_dma,
  input  logic [LEVELS-1:0]  int_set,
  input  logic [LEVELS-1:0]  pend_clr,
  input  logic [FAULT_W-1:0] fault_clr,
  input  logic               cfg_we,
  input  logic [LEVELS-1:0]  mask_wdata,
  input  logic               en_wdata,
  output logic [LEVELS-1:0]  pending,
  output logic [FAULT_W-1:0] fault,
  output logic [LEVELS-1:0]  mask_q,
  output logic               int_en,
  output logic               irq_valid,
  output logic [LW-1:0]      irq_level,
  output logic               abort_req
);
  logic               sync_fall;
  logic [LEVELS-1:0]  pend_set;
  logic [FAULT_W-1:0] fault_set;
  logic               abort_set;

  ifc_sync_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (sync_n),
    .fall     (sync_fall)
  );

  ifc_capture #(
    .LEVELS (LEVELS), .FAULT_W (FAULT_W), .NUM_USR (NUM_USR), .NUM_IO (NUM_IO)
  ) u_cap (
    .take         (sync_fall),
    .pwr_n        (pwr_dn_n),
    .usr_n        (usr_irq_n),
    .io_n         (io_irq_n),
    .prot_n       (prot_err_n),
    .mpar_n       (mem_par_err_n),
    .pio_n        (pio_par_err_n),
    .dpar_n       (dma_par_err_n),
    .addr_n       (addr_err_n),
    .is_dma       (cyc_is_dma),
    .internal_set (int_set),
    .pend_set     (pend_set),
    .fault_set    (fault_set),
    .abort_set    (abort_set)
  );

  ifc_w1c_reg #(.W (LEVELS)) u_pend (
    .clk (clk), .rst (rst), .set_bits (pend_set), .clr_bits (pend_clr), .q (pending)
  );

  ifc_w1c_reg #(.W (FAULT_W)) u_fault (
    .clk (clk), .rst (rst), .set_bits (fault_set), .clr_bits (fault_clr), .q (fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      int_en    <= 1'b0;
      abort_req <= 1'b0;
    end else begin
      if (cfg_we) begin
        mask_q <= mask_wdata;
        int_en <= en_wdata;
      end
      abort_req <= abort_set;
    end
  end

  ifc_prio #(.LEVELS (LEVELS)) u_prio (
    .clk    (clk),
    .rst    (rst),
    .pend   (pending),
    .mask   (mask_q),
    .enable (int_en),
    .valid  (irq_valid),
    .level  (irq_level)
  );
endmodule

// File: rtl/ifc_checker.sv
module ifc_checker #(
  parameter int LEVELS  = 16,
  parameter int FAULT_W = 16,
  localparam int LW     = $clog2(LEVELS)
) (
  input logic               clk,
  input logic               rst,
  input logic               sync_fall,
  input logic [LEVELS-1:0]  int_set,
  input logic [LEVELS-1:0]  pend_clr,
  input logic [LEVELS-1:0]  pending,
  input logic [FAULT_W-1:0] fault,
  input logic               irq_valid,
  input logic [LW-1:0]      irq_level,
  input logic               abort_req
);
  logic [LEVELS-1:0] pend_d;

  always_ff @(posedge clk) begin
    if (rst) pend_d <= '0;
    else     pend_d <= pending;
  end

  // R2: with no edge, no internal set and no clear, pending holds
  p_quiet_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!sync_fall && int_set == '0 && pend_clr == '0) |=> $stable(pending));

  // R3: power-down level always wins the next cycle
  p_lvl0_wins_r3: assert property (@(posedge clk) disable iff (rst)
    pending[0] |=> (irq_valid && irq_level == '0));

  // R5: a fault appearing is accompanied by pending level 1
  p_fault_raises_l1_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(|fault) |-> pending[1]);

  // R6: abort only with a memory-cycle protect fault recorded
  p_abort_has_fault_r6: assert property (@(posedge clk) disable iff (rst)
    abort_req |-> fault[0]);

  // R6: abort lasts a single cycle
  p_abort_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    abort_req |=> !abort_req);

  // R9: a granted level was pending in the state it was chosen from
  p_grant_pending_r9: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> pend_d[irq_level]);
endmodule

bind intr_fault_capture ifc_checker #(.LEVELS (LEVELS), .FAULT_W (FAULT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sync_fall (sync_fall),
  .int_set   (int_set),
  .pend_clr  (pend_clr),
  .pending   (pending),
  .fault     (fault),
  .irq_valid (irq_valid),
  .irq_level (irq_level),
  .abort_req (abort_req)
);

// File: tb/intr_fault_capture_test.sv
`timescale 1ns/1ps
module intr_fault_capture_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_n = 1'b1, pwr_dn_n = 1'b1;
  logic [5:0]  usr_irq_n = '1;
  logic [1:0]  io_irq_n = '1;
  logic        prot_err_n = 1'b1, mem_par_err_n = 1'b1, pio_par_err_n = 1'b1;
  logic        dma_par_err_n = 1'b1, addr_err_n = 1'b1, cyc_is_dma = 1'b0;
  logic [15:0] int_set = '0, pend_clr = '0, fault_clr = '0, mask_wdata = '0;
  logic        cfg_we = 1'b0, en_wdata = 1'b0;
  logic [15:0] pending, fault, mask_q;
  logic        int_en, irq_valid, abort_req;
  logic [3:0]  irq_level;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_pend, m_fault, m_mask;
  logic        m_en, m_sprev, m_valid, m_abort;
  logic [3:0]  m_level;

  always #4 clk = ~clk;

  intr_fault_capture uut (
    .clk, .rst, .sync_n, .pwr_dn_n, .usr_irq_n, .io_irq_n, .prot_err_n,
    .mem_par_err_n, .pio_par_err_n, .dma_par_err_n, .addr_err_n, .cyc_is_dma,
    .int_set, .pend_clr, .fault_clr, .cfg_we, .mask_wdata, .en_wdata,
    .pending, .fault, .mask_q, .int_en, .irq_valid, .irq_level, .abort_req
  );

  function automatic int lvl_of_user(input int i);
    int t[6] = '{2, 8, 10, 11, 13, 15};
    return t[i];
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    pwr_dn_n = 1; usr_irq_n = '1; io_irq_n = '1; prot_err_n = 1;
    mem_par_err_n = 1; pio_par_err_n = 1; dma_par_err_n = 1; addr_err_n = 1;
    int_set = '0; pend_clr = '0; fault_clr = '0; cfg_we = 0;
  endtask

  // advance one clock: model update from driven inputs, then compare at negedge
  task automatic step();
    logic        e;
    logic [15:0] ps, fs;
    e  = m_sprev & ~sync_n;
    ps = '0; fs = '0;
    if (e) begin
      ps[0] = ~pwr_dn_n;
      for (int i = 0; i < 6; i++) if (!usr_irq_n[i]) ps[lvl_of_user(i)] = 1;
      if (!io_irq_n[0]) ps[12] = 1;
      if (!io_irq_n[1]) ps[14] = 1;
      fs[0] = ~prot_err_n & ~cyc_is_dma;
      fs[1] = ~prot_err_n & cyc_is_dma;
      fs[2] = ~mem_par_err_n;
      fs[3] = ~pio_par_err_n;
      fs[4] = ~dma_par_err_n;
      fs[8] = ~addr_err_n;
      if (fs != 0) ps[1] = 1;
    end
    ps |= int_set & 16'h02FA;
    m_valid = 0; m_level = 0;
    if (m_pend[0]) m_valid = 1;
    else if (m_en)
      for (int i = 1; i < 16; i++)
        if (!m_valid && m_pend[i] && m_mask[i]) begin m_valid = 1; m_level = 4'(i); end
    m_pend  = (m_pend & ~pend_clr) | ps;
    m_fault = (m_fault & ~fault_clr) | fs;
    if (cfg_we) begin m_mask = mask_wdata; m_en = en_wdata; end
    m_abort = e & ~prot_err_n & ~cyc_is_dma;
    m_sprev = sync_n;
    @(posedge clk);
    @(negedge clk);
    check("R2 R3 R4 R7 R8 R10 pending", pending, m_pend);
    check("R5 R8 fault", fault, m_fault);
    check("R9 mask", mask_q, m_mask);
    check("R9 enable", {15'b0, int_en}, {15'b0, m_en});
    check("R3 R9 valid", {15'b0, irq_valid}, {15'b0, m_valid});
    check("R3 R9 level", {12'b0, irq_level}, {12'b0, m_level});
    check("R6 abort", {15'b0, abort_req}, {15'b0, m_abort});
  endtask

  initial begin
    m_pend = 0; m_fault = 0; m_mask = 0; m_en = 0; m_sprev = 1;
    m_valid = 0; m_abort = 0; m_level = 0;
    void'($urandom(32'h1750_2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 pending in reset", pending, 16'h0);
    check("R1 fault in reset", fault, 16'h0);
    rst = 0;
    @(posedge clk); @(negedge clk);
    check("R1 mask after reset", mask_q, 16'h0);
    check("R1 outputs after reset", {12'b0, int_en, irq_valid, abort_req, 1'b0}, 16'h0);

    // R2: low inputs without a falling strobe edge are ignored
    usr_irq_n = '0; io_irq_n = '0; pwr_dn_n = 0; prot_err_n = 0; mem_par_err_n = 0;
    repeat (3) step();
    check("R2 no edge pending", pending, 16'h0);
    check("R2 no edge fault", fault, 16'h0);
    idle_inputs();

    // R4: user level 8 held low while being cleared on the same edge -> R8 set wins
    usr_irq_n[1] = 0; sync_n = 0; pend_clr = 16'h0100;
    step();
    check("R8 set beats clear", pending & 16'h0100, 16'h0100);
    sync_n = 1; pend_clr = 16'h0100; step();
    check("R8 clear", pending & 16'h0100, 16'h0000);
    // R10: still low, next edge sets again
    pend_clr = 0; sync_n = 0; step();
    check("R10 reset on next edge", pending & 16'h0100, 16'h0100);
    idle_inputs(); sync_n = 1; pend_clr = '1; step(); pend_clr = 0;

    // R5 R6: protect error in memory cycle vs DMA cycle
    prot_err_n = 0; cyc_is_dma = 0; sync_n = 0; step();
    check("R5 mem protect fault", fault, 16'h0001);
    check("R6 abort raised", {15'b0, abort_req}, 16'h1);
    sync_n = 1; cyc_is_dma = 1; step();
    check("R6 abort one cycle", {15'b0, abort_req}, 16'h0);
    sync_n = 0; step();
    check("R5 dma protect fault", fault, 16'h0003);
    check("R6 no abort dma", {15'b0, abort_req}, 16'h0);
    idle_inputs(); sync_n = 1; pend_clr = '1; fault_clr = '1; step();
    pend_clr = 0; fault_clr = 0;

    // R7: internal set only at reserved levels
    int_set = 16'hFFFF; step(); int_set = 0;
    check("R7 reserved only", pending, 16'h02FA);
    // R9: mask and enable select lowest eligible
    cfg_we = 1; mask_wdata = 16'h0208; en_wdata = 1; step(); cfg_we = 0;
    step();
    check("R9 lowest eligible", {12'b0, irq_level}, 16'd3);
    pend_clr = '1; step(); pend_clr = 0;

    // random phase
    for (int n = 0; n < 3000; n++) begin
      sync_n        = ($urandom % 3) != 0;
      pwr_dn_n      = ($urandom % 16) != 0;
      for (int b = 0; b < 6; b++) usr_irq_n[b] = ($urandom % 4) != 0;
      for (int b = 0; b < 2; b++) io_irq_n[b] = ($urandom % 4) != 0;
      prot_err_n    = ($urandom % 6) != 0;
      mem_par_err_n = ($urandom % 8) != 0;
      pio_par_err_n = ($urandom % 8) != 0;
      dma_par_err_n = ($urandom % 8) != 0;
      addr_err_n    = ($urandom % 8) != 0;
      cyc_is_dma    = $urandom % 2;
      int_set       = (($urandom % 6) == 0) ? 16'($urandom) : 16'h0;
      pend_clr      = (($urandom % 3) == 0) ? 16'($urandom) : 16'h0;
      fault_clr     = (($urandom % 4) == 0) ? 16'($urandom) : 16'h0;
      cfg_we        = ($urandom % 10) == 0;
      mask_wdata    = 16'($urandom);
      en_wdata      = ($urandom % 4) != 0;
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule